// File: doc/BRIEF.md
# Microcontroller Internal Data Memory Unit

This block is the on-chip data store of an 8-bit microcontroller core. The core hands it one request per cycle. A request is a byte read or write, or a single-bit read, set, clear or write. Each byte request also carries an addressing mode: direct, indirect or register-relative. The block decides whether the request lands in its 128 bytes of physical RAM or goes out to the special-function-register (SFR) space. It forwards SFR traffic over a simple same-cycle request/response port and keeps no SFR contents itself.

Below 80H, the direct and indirect modes reach the same RAM bytes. Above 7FH they split. Direct accesses leave the block as SFR requests. Indirect accesses fold back onto the RAM because the upper half is not built. Register operands R0 to R7 are relocated by the two bank-select bits the core supplies. The bit space has two halves. Bit addresses below 80H fall in a sixteen-byte RAM window starting at 20H. Bit addresses from 80H upward fall on the SFR bytes whose low three address bits are zero. Bit modifications are done as read-modify-write, so the other seven bits of the byte are kept. The block also exports the stack-pointer reset constant, so the first push lands just above register bank 0.

Top module: `idm_unit`

## Requirements
- R1: A byte access at an address below 80H, in direct or indirect mode (req_mode 0 or 1), reads or writes that same RAM byte, and no SFR request is raised.
- R2: A direct-mode (req_mode 0) byte access at 80H or above raises sfr_req in the same cycle, with sfr_addr equal to the request address and sfr_we high only for writes; RAM is not changed.
- R3: An indirect-mode (req_mode 1) byte access at 80H or above ignores address bit 7 and reaches RAM byte addr-80H, with no SFR request.
- R4: A register-mode (req_mode 2) byte access uses req_addr[2:0] as register number n and reaches RAM byte bank_sel*8+n; req_addr[7:3] is ignored.
- R5: A bit request (req_kind 2 to 5) with bit address b below 80H acts on RAM byte 20H+b[6:3], bit b[2:0]; req_mode is ignored.
- R6: A bit request with bit address b at 80H or above raises sfr_req with sfr_addr = {b[7:3],000} and acts on bit b[2:0] of that SFR byte.
- R7: Bit set (kind 3), clear (kind 4) and write (kind 5, value from req_bitval) change only the addressed bit and preserve the other seven bits, in RAM and in SFR space (sfr_wdata carries the merged byte).
- R8: For a byte read (kind 0) or bit read (kind 2), rsp_valid is high exactly one cycle later, with rsp_data holding the byte and rsp_bit holding the addressed bit. Other kinds give no response. A write is visible to a read issued in the next cycle.
- R9: sp_reset_val is constant 07H.
- R10: After reset, rsp_valid is low, and no SFR request is raised while req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 byte read, 1 byte write, 2 bit read, 3 bit set, 4 bit clear, 5 bit write, 6/7 no operation |
| req_mode | input | 2 | Byte addressing mode: 0 direct, 1 indirect, 2 register |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wdata | input | 8 | Byte write data |
| req_bitval | input | 1 | Value for a bit write |
| bank_sel | input | 2 | Register bank select from the status word |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 8 | Byte read, or the byte that holds the bit read |
| rsp_bit | output | 1 | Addressed bit of a bit read |
| sfr_req | output | 1 | SFR access this cycle |
| sfr_we | output | 1 | SFR access writes |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write byte (merged for bit operations) |
| sfr_rdata | input | 8 | SFR read byte, returned in the same cycle |
| sp_reset_val | output | 8 | Stack-pointer reset constant |

## Verification
The SFR port lines are combinational, so they are due in the same cycle as the request. The bench samples them at the falling edge halfway through that cycle. Read responses pass through one register, so they are due after the next rising edge. The bench samples them at the following falling edge, and it drives the next request at that same moment, which lets back-to-back write-then-read pairs test the visibility rule. A behavioural model of the RAM and the SFR contents predicts every value. Directed sequences cover aliasing, all four banks and bit operations in both spaces, and a random mix follows them.

// File: rtl/idm_pkg.sv
package idm_pkg;

  typedef enum logic [2:0] {
    OP_RD_BYTE = 3'd0,
    OP_WR_BYTE = 3'd1,
    OP_RD_BIT  = 3'd2,
    OP_SET_BIT = 3'd3,
    OP_CLR_BIT = 3'd4,
    OP_WR_BIT  = 3'd5
  } op_kind_e;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_REGISTER = 2'd2
  } addr_mode_e;

  function automatic logic kind_is_bit(input logic [2:0] k);
    return (k >= 3'd2) && (k <= 3'd5);
  endfunction

  function automatic logic kind_is_read(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd2);
  endfunction

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k == 3'd1) || ((k >= 3'd3) && (k <= 3'd5));
  endfunction

endpackage

// File: rtl/idm_map.sv
module idm_map
  import idm_pkg::*;
#(
  parameter int AW       = 8,
  parameter int RAW      = 7,
  parameter int BSW      = 2,
  parameter int RNW      = 3,
  parameter int PW       = 3,
  parameter int BIT_BASE = 32
) (
  input  logic [2:0]     kind,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  addr,
  input  logic [BSW-1:0] bank_sel,
  output logic           to_sfr,
  output logic [RAW-1:0] ram_addr,
  output logic [AW-1:0]  sfr_addr,
  output logic [PW-1:0]  bit_pos
);

  always_comb begin
    to_sfr   = 1'b0;
    ram_addr = addr[RAW-1:0];
    sfr_addr = addr;
    bit_pos  = '0;
    if (kind_is_bit(kind)) begin
      bit_pos = addr[PW-1:0];
      if (addr[AW-1]) begin
        to_sfr   = 1'b1;
        sfr_addr = {addr[AW-1:PW], {PW{1'b0}}};
      end else begin
        ram_addr = RAW'(BIT_BASE) + RAW'(addr[AW-2:PW]);
      end
    end else begin
      case (mode)
        AM_REGISTER: ram_addr = RAW'({bank_sel, addr[RNW-1:0]});
        AM_INDIRECT: ram_addr = addr[RAW-1:0];
        default:     to_sfr   = addr[AW-1];
      endcase
    end
  end

endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic row_en;
    assign row_en = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (row_en) mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/idm_bitmerge.sv
module idm_bitmerge
  import idm_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 3
) (
  input  logic [DW-1:0] cur,
  input  logic [PW-1:0] pos,
  input  logic [2:0]    kind,
  input  logic          bitval,
  output logic [DW-1:0] merged,
  output logic          sel_bit
);

  logic new_bit;

  always_comb begin
    case (kind)
      OP_SET_BIT: new_bit = 1'b1;
      OP_CLR_BIT: new_bit = 1'b0;
      default:    new_bit = bitval;
    endcase
    merged      = cur;
    merged[pos] = new_bit;
    sel_bit     = cur[pos];
  end

endmodule

// File: rtl/idm_unit.sv
module idm_unit
  import idm_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          AW        = 8,
  parameter int          RAM_BYTES = 128,
  parameter int          BANK_REGS = 8,
  parameter int          NUM_BANKS = 4,
  parameter int          BIT_BASE  = 32,
  parameter logic [7:0]  SP_RESET  = 8'h07,
  localparam int         RAW       = $clog2(RAM_BYTES),
  localparam int         BSW       = $clog2(NUM_BANKS),
  localparam int         RNW       = $clog2(BANK_REGS),
  localparam int         PW        = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_bitval,
  input  logic [1:0]    bank_sel,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_bit,
  output logic          sfr_req,
  output logic          sfr_we,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata,
  output logic [7:0]    sp_reset_val
);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // address resolution
  logic           to_sfr;
  logic [RAW-1:0] ram_addr;
  logic [AW-1:0]  map_sfr_addr;
  logic [PW-1:0]  bit_pos;

  idm_map #(
    .AW(AW), .RAW(RAW), .BSW(BSW), .RNW(RNW), .PW(PW), .BIT_BASE(BIT_BASE)
  ) u_map (
    .kind(req_kind), .mode(req_mode), .addr(req_addr), .bank_sel(bank_sel[BSW-1:0]),
    .to_sfr(to_sfr), .ram_addr(ram_addr), .sfr_addr(map_sfr_addr), .bit_pos(bit_pos)
  );

  // storage
  logic          req_act, is_rd, is_wr, is_bit;
  logic          ram_we;
  logic [DW-1:0] ram_rdata, cur_byte, merged, wr_byte;
  logic          sel_bit;

  assign req_act = req_valid && rst_i_n;
  assign is_rd   = kind_is_read(req_kind);
  assign is_wr   = kind_is_write(req_kind);
  assign is_bit  = kind_is_bit(req_kind);

  idm_ram #(.DEPTH(RAM_BYTES), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(wr_byte),
    .raddr(ram_addr), .rdata(ram_rdata)
  );

  assign cur_byte = to_sfr ? sfr_rdata : ram_rdata;

  idm_bitmerge #(.DW(DW), .PW(PW)) u_merge (
    .cur(cur_byte), .pos(bit_pos), .kind(req_kind), .bitval(req_bitval),
    .merged(merged), .sel_bit(sel_bit)
  );

  assign wr_byte   = is_bit ? merged : req_wdata;
  assign ram_we    = req_act && is_wr && !to_sfr;
  assign sfr_req   = req_act && to_sfr;
  assign sfr_we    = sfr_req && is_wr;
  assign sfr_addr  = map_sfr_addr;
  assign sfr_wdata = wr_byte;

  // response: next state
  logic          rsp_valid_d, rsp_en, rsp_bit_d;
  logic [DW-1:0] rsp_data_d;

  always_comb begin
    rsp_valid_d = req_act && is_rd;
    rsp_en      = req_act && is_rd;
    rsp_data_d  = cur_byte;
    rsp_bit_d   = sel_bit;
  end

  // response: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_bit   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (rsp_en) begin
        rsp_data <= rsp_data_d;
        rsp_bit  <= rsp_bit_d;
      end
    end
  end

  assign sp_reset_val = SP_RESET;

endmodule

// File: rtl/idm_chk.sv
module idm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic [1:0] req_mode,
  input logic [7:0] req_addr,
  input logic       rsp_valid,
  input logic       sfr_req,
  input logic       sfr_we,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata
);

  logic byte_op, bit_op, rd_op;
  assign byte_op = (req_kind == 3'd0) || (req_kind == 3'd1);
  assign bit_op  = (req_kind >= 3'd2) && (req_kind <= 3'd5);
  assign rd_op   = (req_kind == 3'd0) || (req_kind == 3'd2);

  // R2
  sfr_direct_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && byte_op && req_mode == 2'd0 && req_addr[7])
      |-> (sfr_req && sfr_addr == req_addr && sfr_we == (req_kind == 3'd1)));

  // R3
  indirect_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && byte_op && req_mode == 2'd1) |-> !sfr_req);

  // R6
  sfr_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bit_op && req_addr[7])
      |-> (sfr_req && sfr_addr[7:3] == req_addr[7:3] && sfr_addr[2:0] == 3'd0));

  // R7
  sfr_bit_set_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd3 && req_addr[7])
      |-> (sfr_we && sfr_wdata == (sfr_rdata | (8'h01 << req_addr[2:0]))));

  // R8
  read_resp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_op) |=> rsp_valid);

  // R8
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rd_op) |=> !rsp_valid);

  // R10
  idle_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !sfr_req);

endmodule

bind idm_unit idm_chk u_idm_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_mode(req_mode), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
);

// File: tb/idm_unit_test.sv
`timescale 1ns/1ps
module idm_unit_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_kind;
  logic [1:0] req_mode;
  logic [7:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_bitval;
  logic [1:0] bank_sel;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       rsp_bit;
  logic       sfr_req;
  logic       sfr_we;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;
  logic [7:0] sp_reset_val;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  idm_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bitval(req_bitval), .bank_sel(bank_sel), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_bit(rsp_bit), .sfr_req(sfr_req), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .sp_reset_val(sp_reset_val)
  );

  // behavioural SFR peripheral
  logic [7:0] sfr_dev [128];
  assign sfr_rdata = sfr_dev[sfr_addr[6:0]];
  always @(posedge clk) if (sfr_req && sfr_we) sfr_dev[sfr_addr[6:0]] <= sfr_wdata;

  // reference model state
  int ram_m [128];
  int sfr_m [128];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the response
  task automatic do_op(input int kind, input int mode, input int addr,
                       input int wd, input int bv, input int bank);
    bit    is_bit, is_rd, is_wr, to_sfr;
    int    idx, pos, cur, nb, val;
    string tag;
    is_bit = (kind >= 2 && kind <= 5);
    is_rd  = (kind == 0 || kind == 2);
    is_wr  = (kind == 1 || (kind >= 3 && kind <= 5));
    to_sfr = 0; pos = 0;
    if (is_bit) begin
      pos = addr % 8;
      if (addr < 128) begin idx = 32 + addr / 8; tag = "R5"; end
      else begin to_sfr = 1; idx = addr & 'hF8; tag = "R6"; end
      if (kind >= 3) tag = "R7";
    end else if (mode == 2) begin
      idx = bank * 8 + addr % 8; tag = "R4";
    end else if (mode == 1) begin
      idx = addr % 128; tag = (addr >= 128) ? "R3" : "R1";
    end else begin
      idx = addr; to_sfr = (addr >= 128); tag = (addr >= 128) ? "R2" : "R1";
    end
    cur = to_sfr ? sfr_m[idx - 128] : ram_m[idx];
    nb  = (kind == 3) ? 1 : (kind == 4) ? 0 : (bv & 1);
    val = is_bit ? ((cur & ~(1 << pos)) | (nb << pos)) : (wd & 255);

    req_valid  = 1'b1;
    req_kind   = 3'(kind);
    req_mode   = 2'(mode);
    req_addr   = 8'(addr);
    req_wdata  = 8'(wd);
    req_bitval = bv[0];
    bank_sel   = 2'(bank);
    #1;
    chk(sfr_req == to_sfr, {tag, " sfr_req"}, sfr_req, to_sfr);
    if (to_sfr) begin
      chk(sfr_addr == 8'(idx), {tag, " sfr_addr"}, sfr_addr, idx);
      chk(sfr_we == is_wr, {tag, " sfr_we"}, sfr_we, is_wr);
      if (is_wr) chk(sfr_wdata == 8'(val), {tag, " sfr_wdata"}, sfr_wdata, val);
    end
    if (is_wr) begin
      if (to_sfr) sfr_m[idx - 128] = val;
      else        ram_m[idx] = val;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == is_rd, "R8 rsp_valid", rsp_valid, is_rd);
    if (is_rd) begin
      chk(rsp_data == 8'(cur), {tag, " rsp_data"}, rsp_data, cur);
      if (is_bit) chk(rsp_bit == ((cur >> pos) & 1), {tag, " rsp_bit"}, rsp_bit, (cur >> pos) & 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      sfr_dev[i] = 8'((i * 37 + 11) & 255);
      sfr_m[i]   = (i * 37 + 11) & 255;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_mode = '0;
    req_addr = '0; req_wdata = '0; req_bitval = 1'b0; bank_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(rsp_valid == 1'b0, "R10 rsp_valid in reset", rsp_valid, 0);
    chk(sfr_req == 1'b0, "R10 sfr_req in reset", sfr_req, 0);
    // R9 stack-pointer constant
    chk(sp_reset_val == 8'h07, "R9 sp_reset_val", sp_reset_val, 7);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", rsp_valid, 0);
    chk(sfr_req == 1'b0, "R10 idle sfr_req", sfr_req, 0);

    // fill RAM directly (R1)
    for (int i = 0; i < 128; i++) do_op(1, 0, i, (i * 5 + 90) & 255, 0, 0);
    do_op(0, 0, 8'h11, 0, 0, 0);
    do_op(0, 1, 8'h11, 0, 0, 0);
    // R8: write then read in the next cycle
    do_op(1, 1, 8'h40, 8'hC3, 0, 0);
    do_op(0, 0, 8'h40, 0, 0, 0);
    // R3 aliasing of indirect upper addresses
    do_op(1, 1, 8'h85, 8'h3C, 0, 0);
    do_op(0, 0, 8'h05, 0, 0, 0);
    do_op(0, 1, 8'hFF, 0, 0, 0);
    // R2 direct upper goes to SFR; RAM below untouched
    do_op(0, 0, 8'h90, 0, 0, 0);
    do_op(1, 0, 8'hA0, 8'h77, 0, 0);
    do_op(0, 0, 8'hA0, 0, 0, 0);
    do_op(0, 0, 8'h20, 0, 0, 0);
    // R4 all four banks, upper address bits junk
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) do_op(1, 2, n | 8'hF8, (b * 16 + n + 1) & 255, 0, b);
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) do_op(0, 0, b * 8 + n, 0, 0, 0);
    do_op(0, 2, 8'h03, 0, 0, 2);
    // R5 R7 RAM bit window
    do_op(1, 0, 8'h22, 8'h00, 0, 0);
    do_op(3, 0, 8'h13, 0, 0, 0);
    do_op(0, 0, 8'h22, 0, 0, 0);
    do_op(1, 0, 8'h20, 8'hFF, 0, 0);
    do_op(4, 1, 8'h00, 0, 0, 0);
    do_op(2, 2, 8'h00, 0, 0, 3);
    do_op(0, 0, 8'h20, 0, 0, 0);
    do_op(5, 0, 8'h7F, 0, 1, 0);
    do_op(0, 0, 8'h2F, 0, 0, 0);
    do_op(5, 0, 8'h7F, 0, 0, 0);
    do_op(2, 0, 8'h7F, 0, 0, 0);
    // R6 R7 SFR bit space
    do_op(3, 0, 8'h83, 0, 0, 0);
    do_op(0, 0, 8'h80, 0, 0, 0);
    do_op(4, 0, 8'hE7, 0, 0, 0);
    do_op(2, 0, 8'hE7, 0, 0, 0);
    do_op(5, 0, 8'hF8, 0, 1, 0);
    do_op(0, 0, 8'hF8, 0, 0, 0);
    // random mix
    for (int k = 0; k < 400; k++)
      do_op(int'($urandom % 6), int'($urandom % 3), int'($urandom % 256),
            int'($urandom % 256), int'($urandom % 2), int'($urandom % 4));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule